// File: doc/BRIEF.md
# Synchronous Pin Sample Streamer

This block sits between a stream of pin commands and a stream of pin readings. The command stream is a valid/ready handshake. Each accepted command carries a value for the output pin, a 4-bit tag and a capture flag. The output pin takes the commanded value one cycle after acceptance. If the capture flag was set, the 8-bit input bus is read in exactly the cycle in which the pin first shows that new value. The input path has an internal synchronizer delay, and the block compensates for it. The reading leaves on the result stream, paired with the command's tag.

Capture requests are tracked from acceptance until their reading is taken by the consumer. Readings wait in a small result queue for the consumer. The command stream is throttled so that requests in flight plus stored readings never exceed the queue depth. A slow consumer therefore stalls the producer rather than losing a reading. Any subset of commands may request a capture, including every command in a row.

Top module: `pin_sample_streamer`

## Requirements
- R1: While reset is held and on the first cycle after it, the output pin is 0, the result stream is not valid and the command stream is ready.
- R2: The output pin takes the value of an accepted command on the cycle after acceptance. In a cycle with no command transfer, the pin keeps its value.
- R3: The reading for a capturing command equals the input bus value during the first cycle in which the pin shows that command's value.
- R4: The capture flag has no effect unless the command is transferred (valid and ready both high). A non-transferred command produces no result.
- R5: Each result carries the 4-bit tag of the command that requested it.
- R6: Every transferred command with the capture flag set yields exactly one result. Results leave in acceptance order, including for back-to-back captures.
- R7: A result presented with ready low stays valid, and its data and tag stay unchanged, until it is taken.
- R8: The command stream's ready is high exactly when fewer than 4 capture requests are outstanding. Outstanding means accepted but not yet taken, whether in flight or stored. That count never exceeds 4.
- R9: A command or result transfers only on a cycle where its valid and ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| outValid | input | 1 | Command valid |
| outReady | output | 1 | Command ready |
| outMeta | input | 4 | Command tag |
| outCapEn | input | 1 | Command requests a capture |
| outPin | input | 1 | Value for the output pin |
| inValid | output | 1 | Result valid |
| inReady | input | 1 | Result ready |
| inMeta | output | 4 | Tag of the result |
| inData | output | 8 | Captured input bus value |
| pinOut | output | 1 | Output pin |
| pinIn | input | 8 | Input bus |

## Verification
The bench builds the block with its defaults: a 4-entry result queue, a 2-stage input delay, a 4-bit tag and an 8-bit bus. A queue this small fills within a few cycles, so every stall, refill and wrap point is reached many times. The bench crosses four command-valid patterns, four capture-flag patterns and four consumer-ready patterns. One consumer pattern never accepts, so the producer must stall. The input bus changes every cycle, so a capture taken one cycle early or late returns a wrong value.

// File: rtl/streamer_pkg.sv
package streamer_pkg;
  typedef struct packed {
    logic accept;  // command transfer this cycle
    logic launch;  // transfer that requests a capture
    logic pop;     // result transfer this cycle
  } strobe_t;
endpackage

// File: rtl/streamer_control.sv
module streamer_control #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic outValid,
  input  logic outCapEn,
  input  logic inReady,
  input  logic landed,
  output logic outReady,
  output logic inValid,
  output streamer_pkg::strobe_t strb,
  output logic [CNT_W-1:0] fifoCount,
  output logic [CNT_W-1:0] pendCount
);
  logic [CNT_W-1:0] total;

  assign total    = pendCount + fifoCount;
  assign outReady = total < CNT_W'(DEPTH);
  assign inValid  = fifoCount != '0;

  always_comb begin
    strb.accept = outValid && outReady;
    strb.launch = strb.accept && outCapEn;
    strb.pop    = inValid && inReady;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fifoCount <= '0;
      pendCount <= '0;
    end else begin
      fifoCount <= fifoCount + CNT_W'(landed) - CNT_W'(strb.pop);
      pendCount <= pendCount + CNT_W'(strb.launch) - CNT_W'(landed);
    end
  end
endmodule

// File: rtl/streamer_datapath.sv
module streamer_datapath #(
  parameter int META_W    = 4,
  parameter int IN_W      = 8,
  parameter int OUT_W     = 1,
  parameter int DEPTH     = 4,
  parameter int CAP_DELAY = 2
) (
  input  logic clk,
  input  logic rst,
  input  streamer_pkg::strobe_t strb,
  input  logic [META_W-1:0] outMeta,
  input  logic [OUT_W-1:0]  outPin,
  input  logic [IN_W-1:0]   pinIn,
  output logic [OUT_W-1:0]  pinOut,
  output logic [META_W-1:0] inMeta,
  output logic [IN_W-1:0]   inData,
  output logic landed
);
  localparam int PTR_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int REQ_STAGES = CAP_DELAY + 1;  // one pin register + capture delay
  localparam int WORD_W     = META_W + IN_W;

  logic [IN_W-1:0]   sampPipe [CAP_DELAY];
  logic              reqValid [REQ_STAGES];
  logic [META_W-1:0] reqMeta  [REQ_STAGES];
  logic [WORD_W-1:0] mem      [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (rst) pinOut <= '0;
    else if (strb.accept) pinOut <= outPin;
  end

  generate
    for (genvar g = 0; g < CAP_DELAY; g++) begin : g_samp
      if (g == 0) begin : g_first
        always_ff @(posedge clk) sampPipe[0] <= pinIn;
      end else begin : g_next
        always_ff @(posedge clk) sampPipe[g] <= sampPipe[g-1];
      end
    end
    for (genvar g = 0; g < REQ_STAGES; g++) begin : g_req
      always_ff @(posedge clk) begin
        if (rst) reqValid[g] <= 1'b0;
        else if (g == 0) reqValid[g] <= strb.launch;
        else reqValid[g] <= reqValid[(g == 0) ? 0 : g-1];
      end
      if (g == 0) begin : g_first
        always_ff @(posedge clk) reqMeta[0] <= outMeta;
      end else begin : g_next
        always_ff @(posedge clk) reqMeta[g] <= reqMeta[g-1];
      end
    end
  endgenerate

  assign landed = reqValid[REQ_STAGES-1];

  always_ff @(posedge clk) begin
    if (landed) mem[wrPtr] <= {reqMeta[REQ_STAGES-1], sampPipe[CAP_DELAY-1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (landed)   wrPtr <= (wrPtr == PTR_W'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (strb.pop) rdPtr <= (rdPtr == PTR_W'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
    end
  end

  assign {inMeta, inData} = mem[rdPtr];
endmodule

// File: rtl/pin_sample_streamer.sv
module pin_sample_streamer #(
  parameter int META_W    = 4,
  parameter int IN_W      = 8,
  parameter int OUT_W     = 1,
  parameter int DEPTH     = 4,
  parameter int CAP_DELAY = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              outValid,
  output logic              outReady,
  input  logic [META_W-1:0] outMeta,
  input  logic              outCapEn,
  input  logic [OUT_W-1:0]  outPin,
  output logic              inValid,
  input  logic              inReady,
  output logic [META_W-1:0] inMeta,
  output logic [IN_W-1:0]   inData,
  output logic [OUT_W-1:0]  pinOut,
  input  logic [IN_W-1:0]   pinIn
);
  localparam int CNT_W = $clog2(DEPTH + 1) + 1;

  streamer_pkg::strobe_t strb;
  logic landed;
  logic [CNT_W-1:0] fifoCount, pendCount;

  streamer_control #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_control (
    .clk(clk), .rst(rst), .outValid(outValid), .outCapEn(outCapEn),
    .inReady(inReady), .landed(landed), .outReady(outReady),
    .inValid(inValid), .strb(strb), .fifoCount(fifoCount),
    .pendCount(pendCount)
  );

  streamer_datapath #(
    .META_W(META_W), .IN_W(IN_W), .OUT_W(OUT_W),
    .DEPTH(DEPTH), .CAP_DELAY(CAP_DELAY)
  ) i_datapath (
    .clk(clk), .rst(rst), .strb(strb), .outMeta(outMeta),
    .outPin(outPin), .pinIn(pinIn), .pinOut(pinOut),
    .inMeta(inMeta), .inData(inData), .landed(landed)
  );
endmodule

// File: rtl/streamer_checker.sv
module streamer_checker #(
  parameter int META_W = 4,
  parameter int IN_W   = 8,
  parameter int OUT_W  = 1,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 4
) (
  input logic clk,
  input logic rst,
  input logic outValid,
  input logic outReady,
  input logic [OUT_W-1:0] outPin,
  input logic [OUT_W-1:0] pinOut,
  input logic inValid,
  input logic inReady,
  input logic [META_W-1:0] inMeta,
  input logic [IN_W-1:0] inData,
  input logic [CNT_W-1:0] fifoCount,
  input logic [CNT_W-1:0] pendCount
);
  assert_pin_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(outValid && outReady) |=> $stable(pinOut));

  assert_pin_load_R2: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady) |=> pinOut == $past(outPin));

  assert_result_held_R7: assert property (@(posedge clk) disable iff (rst)
    (inValid && !inReady) |=> (inValid && $stable(inData) && $stable(inMeta)));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (pendCount + fifoCount) <= CNT_W'(DEPTH));

  assert_ready_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    ((pendCount + fifoCount) == CNT_W'(DEPTH)) |-> !outReady);
endmodule

bind pin_sample_streamer streamer_checker #(
  .META_W(META_W), .IN_W(IN_W), .OUT_W(OUT_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) i_checker (
  .clk(clk), .rst(rst), .outValid(outValid), .outReady(outReady),
  .outPin(outPin), .pinOut(pinOut), .inValid(inValid), .inReady(inReady),
  .inMeta(inMeta), .inData(inData), .fifoCount(fifoCount),
  .pendCount(pendCount)
);

// File: tb/test_pin_sample_streamer.sv
module test_pin_sample_streamer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic outValid = 1'b0, outCapEn = 1'b0, inReady = 1'b0;
  logic [3:0] outMeta = '0;
  logic [0:0] outPin = '0;
  logic [7:0] pinIn = '0;
  logic outReady, inValid;
  logic [3:0] inMeta;
  logic [7:0] inData;
  logic [0:0] pinOut;

  pin_sample_streamer i_pin_sample_streamer (
    .clk(clk), .rst(rst), .outValid(outValid), .outReady(outReady),
    .outMeta(outMeta), .outCapEn(outCapEn), .outPin(outPin),
    .inValid(inValid), .inReady(inReady), .inMeta(inMeta),
    .inData(inData), .pinOut(pinOut), .pinIn(pinIn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit running = 0, drain = 0, done = 0;
  logic [15:0] vMask, eMask, rMask;
  int cyc = 0, outstanding = 0;
  logic [3:0] metaSeq = '0;
  logic pinVal = 1'b0, expPin = 1'b0;
  logic lastAccEn = 1'b0, held = 1'b0;
  logic [3:0] lastAccMeta = '0;
  logic [11:0] heldWord = '0;
  logic [11:0] expQ[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      int idx;
      logic pop, acc;
      idx = cyc % 16;
      check(pinOut[0] === expPin, "R2 pin value", int'(pinOut), int'(expPin));
      check(outReady === (outstanding < 4), "R8 ready vs outstanding", int'(outReady), int'(outstanding < 4));
      check(outstanding <= 4, "R8 outstanding bound", outstanding, 4);
      if (held)
        check(inValid === 1'b1 && {inMeta, inData} === heldWord, "R7 held result",
              int'({inMeta, inData}), int'(heldWord));
      // new input bus value for the cycle now under way
      pinIn = 8'(cyc * 37 + 11);
      if (lastAccEn) expQ.push_back({lastAccMeta, pinIn});
      // consumer
      inReady = drain ? 1'b1 : rMask[idx];
      pop = inValid && inReady;
      if (pop) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R4 R6 unexpected result", int'({inMeta, inData}), 0);
        end else begin
          check({inMeta, inData} === expQ[0], "R3 R5 R6 result word",
                int'({inMeta, inData}), int'(expQ[0]));
          void'(expQ.pop_front());
        end
        outstanding--;
      end
      held = inValid && !inReady;
      heldWord = {inMeta, inData};
      // producer (capture flag driven even when not valid: R4)
      outValid = !drain && vMask[idx];
      outCapEn = eMask[idx];
      outMeta = metaSeq;
      outPin = pinVal;
      acc = outValid && outReady;
      lastAccEn = acc && outCapEn;
      lastAccMeta = outMeta;
      if (acc) begin
        expPin = pinVal;
        pinVal = ~pinVal;
        metaSeq = metaSeq + 4'd1;
        if (outCapEn) outstanding++;
      end
      cyc++;
    end
  end

  initial begin
    logic [15:0] vList[4], eList[4], rList[4];
    vList = '{16'hFFFF, 16'h5555, 16'h7BDE, 16'h0F0F};
    eList = '{16'hFFFF, 16'hAAAA, 16'h0000, 16'h3A6C};
    rList = '{16'hFFFF, 16'h0000, 16'h1111, 16'hE7C3};
    vMask = '0; eMask = '0; rMask = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pinOut === 1'b0, "R1 reset pin", int'(pinOut), 0);
    check(inValid === 1'b0, "R1 reset result valid", int'(inValid), 0);
    check(outReady === 1'b1, "R1 reset ready", int'(outReady), 1);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check(pinOut === 1'b0 && inValid === 1'b0 && outReady === 1'b1, "R1 after reset",
          int'({pinOut, inValid, outReady}), 1);
    @(posedge clk); #1;
    running = 1;
    for (int v = 0; v < 4; v++)
      for (int e = 0; e < 4; e++)
        for (int r = 0; r < 4; r++) begin
          vMask = vList[v]; eMask = eList[e]; rMask = rList[r]; drain = 0;
          repeat (40) @(posedge clk);
          #1 drain = 1;
          repeat (30) @(posedge clk);
          @(negedge clk); #1;
          check(expQ.size() == 0 && outstanding == 0, "R4 R6 R9 all results delivered",
                expQ.size(), 0);
          check(inValid === 1'b0, "R6 no extra result", int'(inValid), 0);
        end
    running = 0;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule